// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared word memory and serves several requesters. Each requester has three ports: a load-linked port, a store-conditional port and a plain store port. A load-linked returns the addressed word in the same cycle. At the next clock edge it arms a reservation for that requester on that word. A store-conditional writes its data only when the requester still holds an unbroken reservation on the same word. Any write by another requester to the reserved word breaks the reservation. This includes a rival store-conditional that wins arbitration.

Writes from plain stores and qualifying store-conditionals go through a fixed-priority arbiter. Requester 0 has the highest priority, and at most one word is written per clock. Write requests use a hold-until-acknowledged handshake, and the acknowledge is combinational in the cycle of the grant. A store-conditional with no valid reservation is answered at once with failure and never enters arbitration. A failed store-conditional never writes the memory.

Each requester runs a reservation state machine with three states. EMPTY means no reservation. ARMED means the reservation is valid. BROKEN means a conflicting write was seen. The transitions are:
- LINK: a load-linked moves the machine to ARMED.
- LINK_STALE: a load-linked in the same cycle as a write to that word moves the machine to BROKEN.
- SNOOP_HIT: another requester's write to the reserved word moves ARMED to BROKEN.
- OWN_STORE: the requester's own store to the reserved word moves ARMED to EMPTY.
- CONSUME: any completed store-conditional moves ARMED or BROKEN to EMPTY.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every memory word reads 0 and no requester holds a reservation. A store-conditional issued before any load-linked gets sc_ack=1 and sc_ok=0 in its own cycle.
- R2: A load-linked returns, on ll_rdata in the same cycle, the word at ll_addr as it stands before that cycle's write. It arms a reservation for that requester on that full word address.
- R3: A store-conditional to the address of an armed reservation that wins arbitration gets sc_ack=1 and sc_ok=1 in that cycle. Its data is in memory from the next cycle.
- R4: A store-conditional with no armed reservation, or to a different address, gets sc_ack=1 and sc_ok=0 in that cycle, without arbitration. It leaves memory unchanged.
- R5: A granted write by another requester (store or store-conditional) to the reserved word cancels the reservation. A write to any other address does not.
- R6: Writes are granted to the lowest-numbered requester with a write request, one per cycle. Within one requester a plain store is served before its store-conditional. A request that is not granted sees ack=0 and may be held.
- R7: When two requesters with armed reservations issue store-conditionals to the same word in the same cycle, the lower index succeeds. The higher index gets sc_ack=0 in that cycle and sc_ack=1, sc_ok=0 in the next.
- R8: A requester's own store to its reserved word clears the reservation, and its own store elsewhere keeps it. Any acknowledged store-conditional, successful or not, clears the reservation.
- R9: A load-linked in the same cycle as a granted write to the same word returns the old word, and its reservation starts cancelled.
- R10: A new load-linked replaces the requester's previous reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ll_req | input | N | Load-linked request per requester |
| ll_addr | input | N*AW | Load-linked word address, requester i at bits [i*AW +: AW] |
| ll_rdata | output | N*DW | Word read for each requester's load-linked |
| sc_req | input | N | Store-conditional request, held until sc_ack |
| sc_addr | input | N*AW | Store-conditional address |
| sc_wdata | input | N*DW | Store-conditional data |
| sc_ack | output | N | Store-conditional completed this cycle |
| sc_ok | output | N | Condition flag: 1 success, 0 failure (valid with sc_ack) |
| st_req | input | N | Plain store request, held until st_ack |
| st_addr | input | N*AW | Plain store address |
| st_wdata | input | N*DW | Plain store data |
| st_ack | output | N | Plain store written this cycle |

## Verification
The bench targets two rival store-conditionals to one word. A design that lets both succeed would leave the loser's data in memory, and one that fails both would report no success at all. It also checks a load-linked in the very cycle another requester writes that word. Treating that reservation as valid would let a stale value be committed. Further cases cover a requester whose own store hits its reservation, a repeated store-conditional after a success, and a load-linked that replaces an older one. Each of these catches a reservation that is not cleared or not replaced. A random phase over four colliding addresses shows any lapse in priority or any write from a failed store-conditional as a memory mismatch on later reads.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        RSV_EMPTY  = 2'd0,
        RSV_ARMED  = 2'd1,
        RSV_BROKEN = 2'd2
    } rsv_state_e;

endpackage

// File: rtl/llsc_wordmem.sv
module llsc_wordmem #(
    parameter int AW  = 6,
    parameter int DW  = 32,
    parameter int NRD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) words[k] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r*DW +: DW] = words[rd_addr[r*AW +: AW]];
    end

endmodule

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k] && !taken) begin
                gnt[k] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot
    import llsc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_req,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_req,
    input  logic [AW-1:0] sc_addr,
    input  logic          sc_done,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_own,
    output logic          sc_fail_fast,
    output logic          sc_may_write
);
    rsv_state_e    state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          snoop_hit;
    logic          link_stale;

    assign snoop_hit  = wr_en && (wr_addr == addr_q);
    assign link_stale = wr_en && (wr_addr == ll_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        if (ll_req) begin
            addr_d  = ll_addr;
            state_d = link_stale ? RSV_BROKEN : RSV_ARMED;
        end else begin
            unique case (state_q)
                RSV_EMPTY: state_d = RSV_EMPTY;
                RSV_ARMED: begin
                    if (sc_done)        state_d = RSV_EMPTY;
                    else if (snoop_hit) state_d = wr_own ? RSV_EMPTY : RSV_BROKEN;
                end
                RSV_BROKEN: begin
                    if (sc_done) state_d = RSV_EMPTY;
                end
                default: state_d = RSV_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        sc_fail_fast = 1'b0;
        sc_may_write = 1'b0;
        unique case (state_q)
            RSV_ARMED: begin
                sc_may_write = sc_req && (sc_addr == addr_q);
                sc_fail_fast = sc_req && (sc_addr != addr_q);
            end
            RSV_EMPTY, RSV_BROKEN: sc_fail_fast = sc_req;
            default: sc_fail_fast = sc_req;
        endcase
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int N  = 4,
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]    ll_req,
    input  logic [N*AW-1:0] ll_addr,
    output logic [N*DW-1:0] ll_rdata,
    input  logic [N-1:0]    sc_req,
    input  logic [N*AW-1:0] sc_addr,
    input  logic [N*DW-1:0] sc_wdata,
    output logic [N-1:0]    sc_ack,
    output logic [N-1:0]    sc_ok,
    input  logic [N-1:0]    st_req,
    input  logic [N*AW-1:0] st_addr,
    input  logic [N*DW-1:0] st_wdata,
    output logic [N-1:0]    st_ack
);
    logic [N-1:0]  fail_fast;
    logic [N-1:0]  sc_cand;
    logic [N-1:0]  wr_req;
    logic [N-1:0]  gnt;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    assign wr_req = st_req | sc_cand;
    assign st_ack = gnt & st_req;
    assign sc_ok  = gnt & ~st_req & sc_req;
    assign sc_ack = sc_ok | fail_fast;
    assign wr_en  = |gnt;

    llsc_prio_arb #(.N(N)) u_arb (
        .req (wr_req),
        .gnt (gnt)
    );

    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        for (int k = 0; k < N; k++) begin
            if (gnt[k]) begin
                wr_addr = st_req[k] ? st_addr[k*AW +: AW]  : sc_addr[k*AW +: AW];
                wr_data = st_req[k] ? st_wdata[k*DW +: DW] : sc_wdata[k*DW +: DW];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        llsc_rsv_slot #(.AW(AW)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .ll_req       (ll_req[i]),
            .ll_addr      (ll_addr[i*AW +: AW]),
            .sc_req       (sc_req[i]),
            .sc_addr      (sc_addr[i*AW +: AW]),
            .sc_done      (sc_ack[i]),
            .wr_en        (wr_en),
            .wr_addr      (wr_addr),
            .wr_own       (gnt[i]),
            .sc_fail_fast (fail_fast[i]),
            .sc_may_write (sc_cand[i])
        );
    end

    llsc_wordmem #(.AW(AW), .DW(DW), .NRD(N)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ll_addr),
        .rd_data (ll_rdata)
    );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int N  = 4,
    parameter int AW = 6,
    parameter int DW = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] ll_req,
    input logic [N-1:0] sc_req,
    input logic [N-1:0] sc_ack,
    input logic [N-1:0] sc_ok,
    input logic [N-1:0] st_req,
    input logic [N-1:0] st_ack,
    input logic         wr_en
);
    a_r6_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sc_ok | st_ack));

    a_r6_top_priority: assert property (@(posedge clk) disable iff (!rst_n)
        st_req[0] |-> st_ack[0]);

    a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_ack & ~st_req) | (sc_ack & ~sc_req)) == '0);

    a_r3_ok_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_ok & ~sc_ack) == '0);

    a_r4_no_write_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_ok == '0 && st_ack == '0) |-> !wr_en);

    for (genvar i = 0; i < N; i++) begin : g_req
        a_r8_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_ack[i] && !ll_req[i]) |=> !sc_ok[i]);
    end

endmodule

bind llsc_monitor llsc_monitor_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ll_req = '0;
    logic [N*AW-1:0] ll_addr = '0;
    logic [N*DW-1:0] ll_rdata;
    logic [N-1:0]    sc_req = '0;
    logic [N*AW-1:0] sc_addr = '0;
    logic [N*DW-1:0] sc_wdata = '0;
    logic [N-1:0]    sc_ack, sc_ok;
    logic [N-1:0]    st_req = '0;
    logic [N*AW-1:0] st_addr = '0;
    logic [N*DW-1:0] st_wdata = '0;
    logic [N-1:0]    st_ack;

    always #2 clk = ~clk;

    llsc_monitor #(.N(N), .AW(AW), .DW(DW)) u0 (.*);

    // behavioural reference
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_rv  [N];
    logic [AW-1:0] m_ra  [N];
    logic [N-1:0]  e_sc_ack, e_sc_ok, e_st_ack;
    bit            e_we;
    logic [AW-1:0] e_wa;
    logic [DW-1:0] e_wd;
    int total = 0;
    int bad = 0;

    task automatic model_eval();
        int win;
        bit ff;
        win = -1;
        e_sc_ack = '0; e_sc_ok = '0; e_st_ack = '0;
        for (int i = 0; i < N; i++) begin
            ff = sc_req[i] && !(m_rv[i] && m_ra[i] == sc_addr[i*AW +: AW]);
            if (ff) e_sc_ack[i] = 1'b1;
            if ((st_req[i] || (sc_req[i] && !ff)) && win < 0) win = i;
        end
        e_we = (win >= 0);
        e_wa = '0; e_wd = '0;
        if (e_we) begin
            if (st_req[win]) begin
                e_st_ack[win] = 1'b1;
                e_wa = st_addr[win*AW +: AW];
                e_wd = st_wdata[win*DW +: DW];
            end else begin
                e_sc_ok[win]  = 1'b1;
                e_sc_ack[win] = 1'b1;
                e_wa = sc_addr[win*AW +: AW];
                e_wd = sc_wdata[win*DW +: DW];
            end
        end
    endtask

    task automatic model_commit();
        for (int i = 0; i < N; i++) begin
            if (ll_req[i]) begin
                m_ra[i] = ll_addr[i*AW +: AW];
                m_rv[i] = !(e_we && e_wa == ll_addr[i*AW +: AW]);
            end else if (e_sc_ack[i]) begin
                m_rv[i] = 1'b0;
            end else if (e_we && e_wa == m_ra[i]) begin
                m_rv[i] = 1'b0;
            end
        end
        if (e_we) m_mem[e_wa] = e_wd;
    endtask

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // called just after a negedge with inputs set; returns at the next negedge
    task automatic cyc(string tag);
        #1;
        model_eval();
        chk(tag, "sc_ack", DW'(sc_ack), DW'(e_sc_ack));
        chk(tag, "sc_ok",  DW'(sc_ok),  DW'(e_sc_ok));
        chk(tag, "st_ack", DW'(st_ack), DW'(e_st_ack));
        for (int i = 0; i < N; i++)
            if (ll_req[i])
                chk(tag, "ll_rdata", ll_rdata[i*DW +: DW], m_mem[ll_addr[i*AW +: AW]]);
        @(posedge clk);
        model_commit();
        @(negedge clk);
    endtask

    task automatic idle();
        ll_req = '0; sc_req = '0; st_req = '0;
    endtask

    task automatic set_ll(int i, int a);
        ll_req[i] = 1'b1; ll_addr[i*AW +: AW] = AW'(a);
    endtask
    task automatic set_sc(int i, int a, logic [DW-1:0] d);
        sc_req[i] = 1'b1; sc_addr[i*AW +: AW] = AW'(a); sc_wdata[i*DW +: DW] = d;
    endtask
    task automatic set_st(int i, int a, logic [DW-1:0] d);
        st_req[i] = 1'b1; st_addr[i*AW +: AW] = AW'(a); st_wdata[i*DW +: DW] = d;
    endtask

    // direct spot check of a memory word through requester 3's load-linked
    task automatic peek(string tag, int a, logic [DW-1:0] exp);
        idle(); set_ll(3, a);
        #1;
        chk(tag, "mem word", ll_rdata[3*DW +: DW], exp);
        @(posedge clk); model_commit(); @(negedge clk);
        idle();
    endtask

    // hold write requests until acknowledged
    task automatic drain(string tag);
        for (int g = 0; g < 20 && (st_req != '0 || sc_req != '0); g++) begin
            cyc(tag);
            ll_req = '0;
            st_req = st_req & ~e_st_ack;
            sc_req = sc_req & ~e_sc_ack;
        end
    endtask

    bit finished = 0;

    initial begin
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
        for (int i = 0; i < N; i++) begin m_rv[i] = 0; m_ra[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle(); cyc("R1");
        set_ll(0, 5); set_sc(1, 5, 32'h1111_0000); cyc("R1");
        idle(); peek("R1", 5, 32'h0);

        // R2, R3 basic link then conditional store
        set_ll(0, 5); cyc("R2"); idle();
        set_sc(0, 5, 32'hAAAA_0005); cyc("R3"); idle();
        peek("R3", 5, 32'hAAAA_0005);
        set_ll(2, 5); cyc("R2"); idle();

        // R4 wrong address and no reservation
        set_ll(1, 7); cyc("R4"); idle();
        set_sc(1, 8, 32'hBAD0_0008); cyc("R4"); idle();
        peek("R4", 8, 32'h0);

        // R5 cancel by other store; unrelated address keeps it
        set_ll(2, 10); cyc("R5"); idle();
        set_st(3, 10, 32'h0000_3310); cyc("R5"); idle();
        set_sc(2, 10, 32'hBAD0_0010); cyc("R5"); idle();
        peek("R5", 10, 32'h0000_3310);
        set_ll(2, 12); cyc("R5"); idle();
        set_st(3, 13, 32'h0000_3313); cyc("R5"); idle();
        set_sc(2, 12, 32'h2222_0012); cyc("R5"); idle();
        peek("R5", 12, 32'h2222_0012);

        // R7 competing conditional stores on one word
        set_ll(0, 20); set_ll(1, 20); cyc("R7"); idle();
        set_sc(0, 20, 32'h0000_0A20); set_sc(1, 20, 32'h0000_0B20);
        drain("R7");
        peek("R7", 20, 32'h0000_0A20);

        // R6 fixed priority among stores, store before conditional in one requester
        set_ll(0, 33); cyc("R6"); idle();
        set_st(1, 30, 32'h6_1); set_st(3, 31, 32'h6_3); set_st(2, 32, 32'h6_2);
        set_st(0, 34, 32'h6_0); set_sc(0, 33, 32'h6_33);
        drain("R6");
        peek("R6", 33, 32'h6_33);
        peek("R6", 31, 32'h6_3);

        // R8 own stores and consumption
        set_ll(1, 40); cyc("R8"); idle();
        set_st(1, 41, 32'h8_41); cyc("R8"); idle();
        set_sc(1, 40, 32'h8_40); cyc("R8"); idle();
        set_sc(1, 40, 32'hBAD8_0040); cyc("R8"); idle();
        peek("R8", 40, 32'h8_40);
        set_ll(1, 42); cyc("R8"); idle();
        set_st(1, 42, 32'h8_42); cyc("R8"); idle();
        set_sc(1, 42, 32'hBAD8_0042); cyc("R8"); idle();
        peek("R8", 42, 32'h8_42);

        // R9 link in the same cycle as a write to that word
        set_ll(2, 50); set_st(0, 50, 32'h9_50); cyc("R9"); idle();
        set_sc(2, 50, 32'hBAD9_0050); cyc("R9"); idle();
        peek("R9", 50, 32'h9_50);

        // R10 newer link replaces older
        set_ll(3, 60); cyc("R10"); idle();
        set_ll(3, 61); cyc("R10"); idle();
        set_sc(3, 60, 32'hBADA_0060); cyc("R10"); idle();
        set_ll(3, 62); cyc("R10"); idle();
        set_sc(3, 62, 32'hA_62); cyc("R10"); idle();
        peek("R10", 62, 32'hA_62);

        // random traffic on a few colliding words
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < N; i++) begin
                ll_req[i] = ($urandom % 3) == 0;
                sc_req[i] = ($urandom % 3) == 0;
                st_req[i] = ($urandom % 5) == 0;
                ll_addr[i*AW +: AW]  = AW'($urandom % 4);
                sc_addr[i*AW +: AW]  = AW'($urandom % 4);
                st_addr[i*AW +: AW]  = AW'($urandom % 4);
                sc_wdata[i*DW +: DW] = $urandom;
                st_wdata[i*DW +: DW] = $urandom;
            end
            cyc("R6");
        end
        idle();
        for (int a = 0; a < 4; a++) peek("R5", a, m_mem[a]);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule